// File: doc/BRIEF.md
# Bit-Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock by dividing the bit stream, read as the coefficients of a polynomial over GF(2), by a fixed generator. A parameter selects one of two generators: a 16-bit one whose register starts from zero, or a 32-bit one of the kind used on Ethernet links, whose register starts from all ones. The input data is not modified. Bit reflection, final inversion and byte-wide input are not provided.

A frame opens with a `start` pulse that also latches the direction. In transmit direction the message bits enter most significant first. After `finish`, the block drives the remainder on `dout` for as many cycles as the generator is wide, leading coefficient first, with `dout_vld` high. The sender appends these bits to the message in place of the zero bits that the division implies. In receive direction the block divides the message and the remainder appended to it. One cycle after `finish` it pulses `chk_done`, and `crc_ok` shows whether the final remainder is zero. `crc_ok` holds that value until the next frame opens.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset `dout_vld`, `chk_done` and `crc_ok` are 0.
- R2: With `CRC_WIDTH`=16 the generator is x^16+x^15+x^2+1 (low bits 16'h8005) and the register presets to zero. A lone message bit 1 then yields remainder 16'h8005. With `CRC_WIDTH`=32 the generator is the 32-bit Ethernet polynomial (low bits 32'h04C11DB7) and the register presets to all ones. A lone message bit 0 then yields 32'hFB3EE249.
- R3: `start` loads the preset and latches `rx_mode` (1 = receive, 0 = transmit). A bit with `din_vld` high in the same cycle is taken as the first message bit. A `start` with `din_vld` low takes no bit.
- R4: Each accepted bit is one division step. The register shifts left, and it is XORed with the generator when its leading bit XOR the input bit is 1. The result equals the remainder of (preset·x^m + M(x)·x^n) mod G(x).
- R5: A cycle with `din_vld` low leaves the division state unchanged, so gaps inside a frame do not alter the remainder.
- R6: In transmit direction, a `finish` cycle also absorbs a valid bit given in that cycle. From the next cycle, `dout_vld` is high for exactly n cycles and `dout` carries the remainder MSB first. After that, `dout_vld` falls.
- R7: While the remainder is being shifted out, `din_vld` and `finish` are ignored and the output sequence is unchanged.
- R8: In receive direction `chk_done` pulses for one cycle, one cycle after `finish`. `crc_ok` is 1 exactly when message plus remainder divide to zero. `crc_ok` holds until the next `start`, which clears it.
- R9: A `start` during shift-out aborts it. `dout_vld` is low from the next cycle, and the new frame is computed from the preset.
- R10: A `finish` while no frame is open has no effect: no `chk_done`, no `dout_vld`, and `crc_ok` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a frame, loads the preset |
| rx_mode | input | 1 | Direction latched at start: 1 receive, 0 transmit |
| din | input | 1 | Serial data bit |
| din_vld | input | 1 | `din` carries a bit this cycle |
| finish | input | 1 | Closes the open frame |
| dout | output | 1 | Remainder bit, MSB first |
| dout_vld | output | 1 | `dout` is valid |
| chk_done | output | 1 | One-cycle pulse: receive check complete |
| crc_ok | output | 1 | Receive remainder was zero |

## Verification
Two pairs of events can fall in the same cycle: the last data bit with `finish`, and a new `start` with a data bit or with an ongoing shift-out. The bench gives the last bit together with `finish` in most frames, and separately in some others. It opens frames with a bit on the `start` cycle and also with `start` alone. It aborts a shift-out after four bits by opening a new frame. Each case is judged against a remainder that the bench computes by long division on a bit queue with the preset folded into the leading coefficients. A same-cycle bit that is dropped or counted twice changes the output bits or the verdict.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SHIFT = 2'd2
  } crc_state_e;

  // Generator coefficients below the leading term, right aligned.
  function automatic logic [31:0] gen_poly(input int w);
    if (w == 16) return 32'h0000_8005;
    else         return 32'h04C1_1DB7;
  endfunction

endpackage

// File: rtl/crc_shift_reg.sv
module crc_shift_reg
  import crc_serial_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         absorb,
  input  logic         bit_in,
  input  logic         drain,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);

  localparam logic [31:0]  POLY_FULL = gen_poly(W);
  localparam logic [W-1:0] POLY      = POLY_FULL[W-1:0];

  logic [W-1:0] preset;
  logic [W-1:0] base;

  generate
    if (W == 32) begin : g_ones
      assign preset = '1;
    end else begin : g_zero
      assign preset = '0;
    end
  endgenerate

  // One step of GF(2) division with the augmenting zeros folded in.
  function automatic logic [W-1:0] div_step(input logic [W-1:0] r, input logic b);
    logic fb;
    fb = r[W-1] ^ b;
    return {r[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  always_comb begin
    base = load ? preset : q;
    if (absorb)     q_next = div_step(base, bit_in);
    else if (drain) q_next = {base[W-2:0], 1'b0};
    else            q_next = base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= preset;
    else        q <= q_next;
  end

  // R5: without any command the division state holds
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !absorb && !drain) |=> $stable(q));

  // R3: a bare start leaves exactly the preset
  p_bare_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !absorb) |=> (q == preset));

endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc_serial_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rx_mode,
  input  logic din_vld,
  input  logic finish,
  input  logic rem_zero_next,
  output logic absorb,
  output logic drain,
  output logic out_vld,
  output logic chk_done,
  output logic crc_ok
);

  localparam int             CW   = $clog2(W);
  localparam logic [CW-1:0]  LAST = CW'(W - 1);

  crc_state_e    state;
  logic          rx_dir;
  logic [CW-1:0] cnt;
  logic          close_frame;
  logic          shift_last;

  assign absorb      = din_vld && (start || state == ST_RUN);
  assign drain       = (state == ST_SHIFT) && !start;
  assign close_frame = finish && (state == ST_RUN) && !start;
  assign shift_last  = (state == ST_SHIFT) && (cnt == LAST);
  assign out_vld     = (state == ST_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rx_dir   <= 1'b0;
      cnt      <= '0;
      chk_done <= 1'b0;
      crc_ok   <= 1'b0;
    end else begin
      chk_done <= 1'b0;
      if (start) begin
        state  <= ST_RUN;
        rx_dir <= rx_mode;
        crc_ok <= 1'b0;
        cnt    <= '0;
      end else begin
        case (state)
          ST_RUN: begin
            if (close_frame) begin
              if (rx_dir) begin
                state    <= ST_IDLE;
                chk_done <= 1'b1;
                crc_ok   <= rem_zero_next;
              end else begin
                state <= ST_SHIFT;
                cnt   <= '0;
              end
            end
          end
          ST_SHIFT: begin
            if (shift_last) state <= ST_IDLE;
            else            cnt   <= cnt + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R8: the check pulse lasts a single cycle
  p_chk_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |=> !chk_done);

  // R8: crc_ok can only rise together with the check pulse
  p_ok_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_ok) |-> chk_done);

  // R6: shift-out stops after the last remainder bit
  p_shift_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_last && !start) |=> !out_vld);

  // R10: finish with no open frame does nothing
  p_idle_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && finish && !start) |=> (!chk_done && !out_vld));

  // R9: start aborts shift-out and clears the verdict
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!out_vld && !crc_ok));

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_serial_pkg::*;
#(
  parameter int CRC_WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rx_mode,
  input  logic din,
  input  logic din_vld,
  input  logic finish,
  output logic dout,
  output logic dout_vld,
  output logic chk_done,
  output logic crc_ok
);

  logic [CRC_WIDTH-1:0] crc_q;
  logic [CRC_WIDTH-1:0] crc_next;
  logic                 absorb;
  logic                 drain;
  logic                 rem_zero_next;

  assign rem_zero_next = (crc_next == '0);

  crc_shift_reg #(.W(CRC_WIDTH)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .absorb (absorb),
    .bit_in (din),
    .drain  (drain),
    .q      (crc_q),
    .q_next (crc_next)
  );

  crc_frame_ctrl #(.W(CRC_WIDTH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .rx_mode       (rx_mode),
    .din_vld       (din_vld),
    .finish        (finish),
    .rem_zero_next (rem_zero_next),
    .absorb        (absorb),
    .drain         (drain),
    .out_vld       (dout_vld),
    .chk_done      (chk_done),
    .crc_ok        (crc_ok)
  );

  assign dout = dout_vld & crc_q[CRC_WIDTH-1];

  // R8/R6: a check verdict and remainder output never share a cycle
  p_out_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dout_vld && chk_done));

endmodule

// File: tb/tb_crc_serial_engine.sv
`timescale 1ns/100ps
module tb_crc_serial_engine;

  typedef bit bq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] st = '0, rxm = '0, d = '0, v = '0, f = '0;
  logic [1:0] dq, dv, cd, ok;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // index 1: 32-bit engine, index 0: 16-bit engine
  crc_serial_engine #(.CRC_WIDTH(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(st[1]), .rx_mode(rxm[1]), .din(d[1]),
    .din_vld(v[1]), .finish(f[1]), .dout(dq[1]), .dout_vld(dv[1]),
    .chk_done(cd[1]), .crc_ok(ok[1]));

  crc_serial_engine #(.CRC_WIDTH(16)) dut16 (
    .clk(clk), .rst_n(rst_n), .start(st[0]), .rx_mode(rxm[0]), .din(d[0]),
    .din_vld(v[0]), .finish(f[0]), .dout(dq[0]), .dout_vld(dv[0]),
    .chk_done(cd[0]), .crc_ok(ok[0]));

  task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Apply inputs for one cycle; returns at the next falling edge.
  task automatic drive(input int k, input bit s, input bit r, input bit b, input bit vv, input bit ff);
    st[k] = s; rxm[k] = r; d[k] = b; v[k] = vv; f[k] = ff;
    @(negedge clk);
  endtask

  task automatic clr(input int k);
    st[k] = 0; rxm[k] = 0; d[k] = 0; v[k] = 0; f[k] = 0;
  endtask

  function automatic int wid(input int k);
    return (k == 1) ? 32 : 16;
  endfunction

  function automatic bq_t gen_msg(input int n, input logic [31:0] seed);
    bq_t q;
    logic [31:0] s = seed;
    for (int i = 0; i < n; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      q.push_back(s[20]);
    end
    return q;
  endfunction

  // Long division of (preset*x^m + M*x^w) by G on an explicit bit queue.
  function automatic logic [31:0] ref_rem(input bq_t msg, input int w);
    bq_t seq;
    logic [32:0] g = (w == 32) ? 33'h1_04C1_1DB7 : 33'h0_0001_8005;
    logic [31:0] pre = (w == 32) ? 32'hFFFF_FFFF : 32'h0;
    logic [31:0] r = '0;
    int m = msg.size();
    seq = msg;
    for (int i = 0; i < w; i++) seq.push_back(1'b0);
    for (int i = 0; i < w; i++) seq[i] = seq[i] ^ pre[w-1-i];
    for (int i = 0; i < m; i++)
      if (seq[i])
        for (int j = 0; j <= w; j++) seq[i+j] = seq[i+j] ^ g[w-j];
    for (int i = 0; i < w; i++) r = {r[30:0], seq[m+i]};
    return r;
  endfunction

  // Transmit frame; checks `stop` output bits against the model.
  task automatic tx_frame(input int k, input int n, input logic [31:0] seed, input bit gaps,
                          input bit junk, input int stop, input bit chk0);
    bq_t msg = gen_msg(n, seed);
    int w = wid(k);
    logic [31:0] rem = ref_rem(msg, w);
    logic [31:0] s = seed ^ 32'h5A5A_0F0F;
    for (int i = 0; i < n; i++) begin
      if (i > 0 || chk0) chk(dv[k] == 1'b0 && cd[k] == 1'b0, "R5 no output while feeding", {30'd0, dv[k], cd[k]}, 32'd0);
      drive(k, i == 0, 1'b0, msg[i], 1'b1, i == n - 1);
      if (gaps && (i % 3 == 1) && i != n - 1) drive(k, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    end
    for (int j = 0; j < stop; j++) begin
      chk(dv[k] == 1'b1, "R6 dout_vld during shift-out", {31'd0, dv[k]}, 32'd1);
      chk(dq[k] == rem[w-1-j], junk ? "R7 remainder bit with ignored inputs" : "R6 remainder bit",
          {31'd0, dq[k]}, {31'd0, rem[w-1-j]});
      s = s * 32'd69069 + 32'd1;
      if (junk) drive(k, 1'b0, 1'b0, s[15], 1'b1, s[17]);
      else      drive(k, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    clr(k);
    if (stop == w) chk(dv[k] == 1'b0 && cd[k] == 1'b0, "R6 dout_vld falls after n bits", {30'd0, dv[k], cd[k]}, 32'd0);
  endtask

  // Receive frame: message plus its remainder, optionally corrupted.
  task automatic rx_frame(input int k, input int n, input logic [31:0] seed, input int bad,
                          input bit late_fin, input bit sep_start, input bit gaps);
    bq_t fr = gen_msg(n, seed);
    int w = wid(k);
    logic [31:0] rem = ref_rem(fr, w);
    int len;
    for (int i = 0; i < w; i++) fr.push_back(rem[w-1-i]);
    if (bad >= 0) fr[bad] = ~fr[bad];
    len = fr.size();
    if (sep_start) drive(k, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < len; i++) begin
      drive(k, (i == 0) && !sep_start, 1'b1, fr[i], 1'b1, (i == len - 1) && !late_fin);
      if (gaps && (i % 5 == 2) && i != len - 1) drive(k, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    end
    if (late_fin) drive(k, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    clr(k);
    chk(cd[k] == 1'b1, "R8 chk_done one cycle after finish", {31'd0, cd[k]}, 32'd1);
    chk(ok[k] == (bad < 0), "R8 crc_ok verdict", {31'd0, ok[k]}, {31'd0, bad < 0});
    @(negedge clk);
    chk(cd[k] == 1'b0 && ok[k] == (bad < 0), "R8 pulse ends, verdict held",
        {30'd0, cd[k], ok[k]}, {31'd0, bad < 0});
  endtask

  task automatic grab(input int k, output logic [31:0] val);
    val = '0;
    for (int j = 0; j < wid(k); j++) begin
      chk(dv[k] == 1'b1, "R2 dout_vld on known value", {31'd0, dv[k]}, 32'd1);
      val = {val[30:0], dq[k]};
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] val;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(dv == 2'b00 && cd == 2'b00 && ok == 2'b00, "R1 reset outputs", {26'd0, dv, cd, ok}, 32'd0);

    // R2 literal remainders, bare start then a one-bit message with finish (R3)
    drive(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    clr(0);
    grab(0, val);
    chk(val == 32'h0000_8005, "R2 CRC-16 of single 1", val, 32'h0000_8005);
    drive(1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    clr(1);
    grab(1, val);
    chk(val == 32'hFB3E_E249, "R2 CRC-32 of single 0", val, 32'hFB3E_E249);

    // R4/R6 transmit frames, with gaps (R5) and junk during shift-out (R7)
    tx_frame(1, 40, 32'h1234_5678, 1'b0, 1'b1, 32, 1'b1);
    tx_frame(1, 57, 32'h0BAD_F00D, 1'b1, 1'b0, 32, 1'b1);
    tx_frame(0, 24, 32'h0000_0077, 1'b1, 1'b1, 16, 1'b1);
    tx_frame(0, 9, 32'hC0FF_EE00, 1'b0, 1'b0, 16, 1'b1);

    // R9 abort shift-out after four bits by a new start
    tx_frame(0, 20, 32'h0000_1111, 1'b0, 1'b0, 4, 1'b1);
    chk(dv[0] == 1'b1, "R9 still shifting before abort", {31'd0, dv[0]}, 32'd1);
    tx_frame(0, 18, 32'h0000_2222, 1'b0, 1'b0, 16, 1'b0);
    tx_frame(1, 33, 32'h0000_3333, 1'b0, 1'b0, 7, 1'b1);
    tx_frame(1, 35, 32'h0000_4444, 1'b1, 1'b0, 32, 1'b0);

    // R8 receive: good, corrupted, late finish, bare start (R3)
    rx_frame(1, 48, 32'hAAAA_0001, -1, 1'b0, 1'b0, 1'b1);
    rx_frame(1, 48, 32'hAAAA_0001, 13, 1'b0, 1'b0, 1'b0);
    rx_frame(1, 40, 32'hAAAA_0002, 45, 1'b1, 1'b1, 1'b0);
    rx_frame(0, 30, 32'hBBBB_0003, -1, 1'b1, 1'b1, 1'b1);
    rx_frame(0, 30, 32'hBBBB_0003, 0, 1'b0, 1'b0, 1'b0);
    rx_frame(0, 25, 32'hBBBB_0004, -1, 1'b0, 1'b0, 1'b0);

    // R10 finish with no open frame leaves the held verdict alone
    drive(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    clr(0);
    chk(cd[0] == 1'b0 && dv[0] == 1'b0 && ok[0] == 1'b1, "R10 idle finish ignored",
        {29'd0, cd[0], dv[0], ok[0]}, 32'd1);
    @(negedge clk);
    chk(ok[0] == 1'b1, "R10 verdict still held", {31'd0, ok[0]}, 32'd1);
    // R8/R3 start clears the verdict
    drive(0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    clr(0);
    chk(ok[0] == 1'b0 && cd[0] == 1'b0, "R8 start clears crc_ok", {30'd0, ok[0], cd[0]}, 32'd0);
    rx_frame(0, 16, 32'hDDDD_0005, -1, 1'b0, 1'b0, 1'b0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule